// File: doc/BRIEF.md
# Fully Interlocked Handshake Link

This block joins two units that run on separate clocks with a request/reply handshake. No edge of the handshake depends on a shared clock. A requesting controller sits in the master's clock domain and a responding controller sits in the slave's clock domain. They talk only through level-signalled strobe lines, reply lines, an address bus, a forward data bus and a reverse data bus. Every incoming strobe or reply passes through a two-flop synchroniser in the controller that receives it. Each edge a controller drives waits until it has seen the partner's preceding edge. A slow partner therefore lengthens the cycle and no transfer is lost.

The master supports three operations. In a push, the master is the source: it drives a word and raises a data-ready strobe, and the slave stores the word and acknowledges. In a pull, the master is the destination: it raises a data-request strobe, and the slave loads its offered buffer word onto the reverse bus and acknowledges. In a memory read, the master sets up an address, raises a master-sync line one clock later, and the slave answers with the word from its local memory on a separate slave-sync line. A push also writes its word into that memory at the pushed address, so a later read returns it. The master flags completion with a done pulse once the partner has released its reply.

Top module: `hs_link`

## Requirements
- R1: While either reset is high and on the cycle after release, m_busy, m_done, m_rdata and s_rx_valid are all 0.
- R2: For m_op = 0 (push), s_rx_valid pulses high for exactly one slave cycle, 4 clock edges after the edge that samples m_start, with s_rx_data equal to m_wdata. Pull and read operations never raise s_rx_valid.
- R3: For m_op = 1 (pull), m_rdata equals the s_buf_data word that the slave captured, and it is valid from the done pulse onward.
- R4: For m_op = 2 (memory read), m_rdata equals the word most recently pushed to m_addr, and it is valid from the done pulse onward.
- R5: With both clocks equal and two synchroniser stages, m_done is a one-cycle pulse 14 edges after the edge that samples m_start. m_busy is high from the next edge until m_done rises, and it falls on the same edge.
- R6: m_start is ignored while m_busy is high, and m_op = 3 never starts a transfer.
- R7: The handshake is fully interlocked. A strobe rises only while its reply line is low. A reply rises only while its strobe is high. A strobe falls only after its reply is high. A reply falls only after its strobe is low.
- R8: At most one master strobe is high at a time. Push and pull are answered on the acknowledge line and read on the slave-sync line, so a read returns memory contents and never the buffer word.
- R9: Address and forward data are captured at start and held from one clock before the strobe rises until the transfer ends. Later changes on m_addr and m_wdata have no effect on the transfer in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_m | input | 1 | Master-side clock |
| rst_m | input | 1 | Master-side synchronous reset, active high |
| m_start | input | 1 | Start a transfer (one-cycle pulse, taken only when idle) |
| m_op | input | 2 | Operation: 0 push, 1 pull, 2 memory read, 3 none |
| m_addr | input | ADDR_W | Word address for push and read |
| m_wdata | input | DATA_W | Word to push |
| m_busy | output | 1 | Transfer in progress |
| m_done | output | 1 | One-cycle completion pulse after the reply is released |
| m_rdata | output | DATA_W | Word returned by the last pull or read |
| clk_s | input | 1 | Slave-side clock |
| rst_s | input | 1 | Slave-side synchronous reset, active high |
| s_buf_data | input | DATA_W | Word the slave offers to a pull |
| s_rx_valid | output | 1 | One-cycle pulse when a pushed word arrives |
| s_rx_data | output | DATA_W | Last pushed word |

## Verification
Each result has a fixed latency, counted from the master edge that samples m_start. The pushed word appears on the slave side 4 edges later. The done pulse and the returned word appear 14 edges later. Each count is the sum of the register stages and synchroniser stages on the path. The bench drives both clocks from one 200 MHz source so these counts are exact. It changes inputs on falling edges and counts falling edges until m_done, so the edge count it compares is the number of falling edges minus one. The bench records the falling edge on which s_rx_valid is seen, and it checks the ignored starts and the held inputs by watching m_busy and reading the stored word back afterwards.

// File: rtl/hs_link_pkg.sv
`timescale 1ns/1ps
package hs_link_pkg;
  typedef enum logic [1:0] {
    OP_PUSH = 2'd0,
    OP_PULL = 2'd1,
    OP_READ = 2'd2,
    OP_NONE = 2'd3
  } hs_op_e;

  typedef enum logic [1:0] {
    M_IDLE,
    M_SETUP,
    M_WAIT_REPLY,
    M_WAIT_RELEASE
  } m_state_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_RESPOND,
    S_HOLD
  } s_state_e;
endpackage

// File: rtl/hs_sync.sv
`timescale 1ns/1ps
module hs_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= '0;
        else     chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hs_store.sv
`timescale 1ns/1ps
module hs_store #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // single-port, read-first, registered read: maps onto a block RAM
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/hs_master.sv
`timescale 1ns/1ps
module hs_master
  import hs_link_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ack_s,
  input  logic              ssyn_s,
  input  logic [DATA_W-1:0] rev_data,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              rdy,
  output logic              req,
  output logic              msyn,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_data
);
  m_state_e state;
  hs_op_e   op_q;
  logic     reply;

  // a read is answered on slave-sync, push and pull on acknowledge
  always_comb begin
    reply = (op_q == OP_READ) ? ssyn_s : ack_s;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= M_IDLE;
      op_q     <= OP_NONE;
      busy     <= 1'b0;
      done     <= 1'b0;
      rdata    <= '0;
      rdy      <= 1'b0;
      req      <= 1'b0;
      msyn     <= 1'b0;
      bus_addr <= '0;
      bus_data <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        M_IDLE: begin
          if (start && (hs_op_e'(op) != OP_NONE)) begin
            op_q     <= hs_op_e'(op);
            bus_addr <= addr;
            bus_data <= wdata;
            busy     <= 1'b1;
            state    <= M_SETUP;
          end
        end
        M_SETUP: begin
          // address and data have been on the bus for one clock
          case (op_q)
            OP_PUSH: rdy  <= 1'b1;
            OP_PULL: req  <= 1'b1;
            OP_READ: msyn <= 1'b1;
            default: ;
          endcase
          state <= M_WAIT_REPLY;
        end
        M_WAIT_REPLY: begin
          if (reply) begin
            if (op_q != OP_PUSH) rdata <= rev_data;
            rdy   <= 1'b0;
            req   <= 1'b0;
            msyn  <= 1'b0;
            state <= M_WAIT_RELEASE;
          end
        end
        M_WAIT_RELEASE: begin
          if (!reply) begin
            done  <= 1'b1;
            busy  <= 1'b0;
            state <= M_IDLE;
          end
        end
        default: state <= M_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hs_slave.sv
`timescale 1ns/1ps
module hs_slave
  import hs_link_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rdy_s,
  input  logic              req_s,
  input  logic              msyn_s,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic [DATA_W-1:0] buf_data,
  output logic              ack,
  output logic              ssyn,
  output logic [DATA_W-1:0] rev_data,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data
);
  s_state_e          state;
  hs_op_e            kind;
  logic              we;
  logic              strobe_now;
  logic [DATA_W-1:0] mem_q;

  assign we = (state == S_IDLE) && rdy_s;

  always_comb begin
    case (kind)
      OP_PUSH: strobe_now = rdy_s;
      OP_PULL: strobe_now = req_s;
      default: strobe_now = msyn_s;
    endcase
  end

  hs_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .clk   (clk),
    .we    (we),
    .addr  (bus_addr),
    .wdata (bus_data),
    .rdata (mem_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      kind     <= OP_NONE;
      ack      <= 1'b0;
      ssyn     <= 1'b0;
      rev_data <= '0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      rx_valid <= 1'b0;
      case (state)
        S_IDLE: begin
          if (rdy_s) begin
            kind     <= OP_PUSH;
            rx_data  <= bus_data;
            rx_valid <= 1'b1;
            state    <= S_RESPOND;
          end else if (req_s) begin
            kind     <= OP_PULL;
            rev_data <= buf_data;
            state    <= S_RESPOND;
          end else if (msyn_s) begin
            kind     <= OP_READ;
            rev_data <= mem_q;
            state    <= S_RESPOND;
          end
        end
        S_RESPOND: begin
          // reverse data has settled for one clock before the reply rises
          if (kind == OP_READ) ssyn <= 1'b1;
          else                 ack  <= 1'b1;
          state <= S_HOLD;
        end
        S_HOLD: begin
          if (!strobe_now) begin
            ack      <= 1'b0;
            ssyn     <= 1'b0;
            rev_data <= '0;
            state    <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hs_link.sv
`timescale 1ns/1ps
module hs_link #(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_m,
  input  logic              rst_m,
  input  logic              m_start,
  input  logic [1:0]        m_op,
  input  logic [ADDR_W-1:0] m_addr,
  input  logic [DATA_W-1:0] m_wdata,
  output logic              m_busy,
  output logic              m_done,
  output logic [DATA_W-1:0] m_rdata,
  input  logic              clk_s,
  input  logic              rst_s,
  input  logic [DATA_W-1:0] s_buf_data,
  output logic              s_rx_valid,
  output logic [DATA_W-1:0] s_rx_data
);
  logic              ln_rdy, ln_req, ln_msyn;
  logic              ln_ack, ln_ssyn;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_fwd, bus_rev;
  logic [1:0]        m_reply_s;
  logic [2:0]        s_strobe_s;

  hs_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync_m (
    .clk (clk_m),
    .rst (rst_m),
    .d   ({ln_ssyn, ln_ack}),
    .q   (m_reply_s)
  );

  hs_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync_s (
    .clk (clk_s),
    .rst (rst_s),
    .d   ({ln_msyn, ln_req, ln_rdy}),
    .q   (s_strobe_s)
  );

  hs_master #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_master (
    .clk      (clk_m),
    .rst      (rst_m),
    .start    (m_start),
    .op       (m_op),
    .addr     (m_addr),
    .wdata    (m_wdata),
    .ack_s    (m_reply_s[0]),
    .ssyn_s   (m_reply_s[1]),
    .rev_data (bus_rev),
    .busy     (m_busy),
    .done     (m_done),
    .rdata    (m_rdata),
    .rdy      (ln_rdy),
    .req      (ln_req),
    .msyn     (ln_msyn),
    .bus_addr (bus_addr),
    .bus_data (bus_fwd)
  );

  hs_slave #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_slave (
    .clk      (clk_s),
    .rst      (rst_s),
    .rdy_s    (s_strobe_s[0]),
    .req_s    (s_strobe_s[1]),
    .msyn_s   (s_strobe_s[2]),
    .bus_addr (bus_addr),
    .bus_data (bus_fwd),
    .buf_data (s_buf_data),
    .ack      (ln_ack),
    .ssyn     (ln_ssyn),
    .rev_data (bus_rev),
    .rx_valid (s_rx_valid),
    .rx_data  (s_rx_data)
  );
endmodule

// File: rtl/hs_link_chk.sv
`timescale 1ns/1ps
module hs_link_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input logic              clk_m,
  input logic              rst_m,
  input logic              clk_s,
  input logic              rst_s,
  input logic              ln_rdy,
  input logic              ln_req,
  input logic              ln_msyn,
  input logic              ln_ack,
  input logic              ln_ssyn,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_fwd,
  input logic [DATA_W-1:0] bus_rev,
  input logic              m_busy,
  input logic              m_done
);
  // master-side edges wait for the slave's previous edge
  p_strobe_rise_r7: assert property (@(posedge clk_m) disable iff (rst_m)
    ($rose(ln_rdy) || $rose(ln_req)) |-> !ln_ack);
  p_msyn_rise_r7: assert property (@(posedge clk_m) disable iff (rst_m)
    $rose(ln_msyn) |-> !ln_ssyn);
  p_strobe_fall_r7: assert property (@(posedge clk_m) disable iff (rst_m)
    ($fell(ln_rdy) || $fell(ln_req)) |-> ln_ack);
  p_msyn_fall_r7: assert property (@(posedge clk_m) disable iff (rst_m)
    $fell(ln_msyn) |-> ln_ssyn);

  // slave-side edges wait for the master's previous edge
  p_ack_rise_r7: assert property (@(posedge clk_s) disable iff (rst_s)
    $rose(ln_ack) |-> (ln_rdy || ln_req));
  p_ssyn_rise_r7: assert property (@(posedge clk_s) disable iff (rst_s)
    $rose(ln_ssyn) |-> ln_msyn);
  p_ack_fall_r7: assert property (@(posedge clk_s) disable iff (rst_s)
    $fell(ln_ack) |-> (!ln_rdy && !ln_req));
  p_ssyn_fall_r7: assert property (@(posedge clk_s) disable iff (rst_s)
    $fell(ln_ssyn) |-> !ln_msyn);

  p_one_strobe_r8: assert property (@(posedge clk_m) disable iff (rst_m)
    $onehot0({ln_rdy, ln_req, ln_msyn}));
  p_one_reply_r8: assert property (@(posedge clk_s) disable iff (rst_s)
    !(ln_ack && ln_ssyn));

  p_bus_hold_r9: assert property (@(posedge clk_m) disable iff (rst_m)
    ((ln_rdy || ln_req || ln_msyn) && $past(ln_rdy || ln_req || ln_msyn))
    |-> ($stable(bus_addr) && $stable(bus_fwd)));
  p_setup_r9: assert property (@(posedge clk_m) disable iff (rst_m)
    ($rose(ln_rdy) || $rose(ln_req) || $rose(ln_msyn)) |-> $past(m_busy));

  p_rev_hold_r3: assert property (@(posedge clk_s) disable iff (rst_s)
    ((ln_ack || ln_ssyn) && $past(ln_ack || ln_ssyn)) |-> $stable(bus_rev));

  p_done_released_r5: assert property (@(posedge clk_m) disable iff (rst_m)
    m_done |-> (!m_busy && !ln_ack && !ln_ssyn));
endmodule

bind hs_link hs_link_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_m    (clk_m),
  .rst_m    (rst_m),
  .clk_s    (clk_s),
  .rst_s    (rst_s),
  .ln_rdy   (ln_rdy),
  .ln_req   (ln_req),
  .ln_msyn  (ln_msyn),
  .ln_ack   (ln_ack),
  .ln_ssyn  (ln_ssyn),
  .bus_addr (bus_addr),
  .bus_fwd  (bus_fwd),
  .bus_rev  (bus_rev),
  .m_busy   (m_busy),
  .m_done   (m_done)
);

// File: tb/test_hs_link.sv
`timescale 1ns/1ps
module test_hs_link;
  localparam int DW       = 16;
  localparam int AW       = 4;
  localparam int LAT_DONE = 14;
  localparam int LAT_RX   = 4;
  localparam int NVEC     = 8;

  // {op[1:0], addr[3:0], wdata[15:0], buf[15:0], expected rdata[15:0]}
  localparam logic [53:0] VEC [NVEC] = '{
    {2'd0, 4'd3, 16'hA5A5, 16'h0000, 16'h0000},
    {2'd0, 4'd9, 16'h1234, 16'h0000, 16'h0000},
    {2'd2, 4'd3, 16'h0000, 16'hFFFF, 16'hA5A5},
    {2'd1, 4'd0, 16'h0000, 16'hBEEF, 16'hBEEF},
    {2'd2, 4'd9, 16'h0000, 16'h7777, 16'h1234},
    {2'd0, 4'd3, 16'h0F0F, 16'h0000, 16'h0000},
    {2'd2, 4'd3, 16'h0000, 16'hEEEE, 16'h0F0F},
    {2'd1, 4'd0, 16'h0000, 16'h0001, 16'h0001}
  };

  logic          clk = 1'b0;
  logic          rst;
  logic          m_start;
  logic [1:0]    m_op;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_wdata;
  logic          m_busy;
  logic          m_done;
  logic [DW-1:0] m_rdata;
  logic [DW-1:0] s_buf_data;
  logic          s_rx_valid;
  logic [DW-1:0] s_rx_data;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  hs_link #(.DATA_W(DW), .ADDR_W(AW)) i_hs_link (
    .clk_m      (clk),
    .rst_m      (rst),
    .m_start    (m_start),
    .m_op       (m_op),
    .m_addr     (m_addr),
    .m_wdata    (m_wdata),
    .m_busy     (m_busy),
    .m_done     (m_done),
    .m_rdata    (m_rdata),
    .clk_s      (clk),
    .rst_s      (rst),
    .s_buf_data (s_buf_data),
    .s_rx_valid (s_rx_valid),
    .s_rx_data  (s_rx_data)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // lat counts falling edges after the start edge; done seen at lat = edges + 1
  task automatic xfer(input logic [1:0] o, input logic [AW-1:0] a,
                      input logic [DW-1:0] w, input logic [DW-1:0] b,
                      output int lat, output int rxl,
                      output logic [DW-1:0] rxd, output logic busy1);
    m_op = o; m_addr = a; m_wdata = w; s_buf_data = b; m_start = 1'b1;
    lat = 0; rxl = -1; rxd = '0; busy1 = 1'b0;
    while (1) begin
      @(negedge clk);
      lat++;
      if (lat == 1) begin
        m_start = 1'b0;
        busy1 = m_busy;
      end
      if (s_rx_valid) begin
        rxl = lat;
        rxd = s_rx_data;
      end
      if (m_done || lat > 200) break;
    end
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int lat, rxl;
    logic [DW-1:0] rxd;
    logic busy1;
    bit saw_busy, saw_done;

    rst = 1'b1; m_start = 1'b0; m_op = 2'd0; m_addr = '0; m_wdata = '0;
    s_buf_data = '0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    check(!m_busy && !m_done && !s_rx_valid, "R1", "flags in reset",
          {m_busy, m_done, s_rx_valid}, 0);
    check(m_rdata == '0, "R1", "rdata in reset", m_rdata, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!m_busy && !m_done && !s_rx_valid && m_rdata == '0, "R1",
          "state after release", {m_busy, m_done, s_rx_valid, m_rdata}, 0);

    // table of transfers
    for (int i = 0; i < NVEC; i++) begin
      logic [53:0] v;
      v = VEC[i];
      xfer(v[53:52], v[51:48], v[47:32], v[31:16], lat, rxl, rxd, busy1);
      check(lat - 1 == LAT_DONE, "R5", "done latency (R7 interlock)",
            lat - 1, LAT_DONE);
      check(busy1 == 1'b1, "R5", "busy after start", busy1, 1);
      if (v[53:52] == 2'd0) begin
        check(rxl - 1 == LAT_RX, "R2", "push arrival edge", rxl - 1, LAT_RX);
        check(rxd == v[47:32], "R2", "pushed word", rxd, v[47:32]);
      end else begin
        check(rxl == -1, "R2", "no arrival on pull/read", rxl, -1);
        if (v[53:52] == 2'd1)
          check(m_rdata == v[15:0], "R3", "pulled word", m_rdata, v[15:0]);
        else
          check(m_rdata == v[15:0], "R4", "read word (R8 not buffer)",
                m_rdata, v[15:0]);
      end
      @(negedge clk);
      check(!m_done, "R5", "done is one cycle", m_done, 0);
    end

    // R6/R9: second start during busy, inputs changed mid-transfer
    m_op = 2'd0; m_addr = 4'd5; m_wdata = 16'h1111; m_start = 1'b1;
    lat = 0;
    while (1) begin
      @(negedge clk);
      lat++;
      if (lat == 1) m_start = 1'b0;
      if (lat == 3) begin
        m_start = 1'b1; m_addr = 4'd5; m_wdata = 16'h2222;
      end
      if (lat == 4) begin
        m_start = 1'b0; m_addr = 4'd6; m_wdata = 16'h3333;
      end
      if (m_done || lat > 200) break;
    end
    check(lat - 1 == LAT_DONE, "R6", "busy start not restarting", lat - 1,
          LAT_DONE);
    saw_busy = 1'b0;
    repeat (20) begin
      @(negedge clk);
      if (m_busy) saw_busy = 1'b1;
    end
    check(!saw_busy, "R6", "no queued transfer", saw_busy, 0);
    xfer(2'd2, 4'd5, 16'h0, 16'hDEAD, lat, rxl, rxd, busy1);
    check(m_rdata == 16'h1111, "R9", "word held from start", m_rdata, 16'h1111);
    xfer(2'd2, 4'd6, 16'h0, 16'hDEAD, lat, rxl, rxd, busy1);
    check(m_rdata != 16'h3333, "R9", "late inputs not written", m_rdata,
          16'h3333);
    @(negedge clk);

    // R6: op code 3 starts nothing
    m_op = 2'd3; m_start = 1'b1;
    saw_busy = 1'b0; saw_done = 1'b0;
    repeat (10) begin
      @(negedge clk);
      m_start = 1'b0;
      if (m_busy) saw_busy = 1'b1;
      if (m_done) saw_done = 1'b1;
    end
    check(!saw_busy && !saw_done, "R6", "op 3 ignored", {saw_busy, saw_done}, 0);

    // R1: reset clears the returned word
    rst = 1'b1;
    @(negedge clk);
    check(m_rdata == '0 && !m_busy, "R1", "rdata cleared by reset", m_rdata, 0);
    rst = 1'b0;
    @(negedge clk);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule